// File: doc/BRIEF.md
# Packed Q15 Rounding Multiply-High Unit

This block is a SIMD datapath that takes two 256-bit operand vectors, splits each into sixteen signed 16-bit lanes, and multiplies matching lanes. Each 32-bit signed product is scaled down by 2^14, incremented by one, and then halved. The result is a rounded Q15-style 16-bit value for every lane, with no saturation. Lanes do not interact.

A two-bit width-mode input controls the upper half of the output vector. The upper half can keep the caller's prior destination value, be cleared to zero, or carry eight more computed lanes. An input valid strobe travels with the data. With the default single output register, the result and its valid flag appear one clock after the strobe.

Top module: `q15_mulhr_unit`

## Requirements
- R1: Each lane result equals bits [16:1] of ((a*b) >>> 14) + 1, where a and b are the signed 16-bit lane operands and the product is a signed 32-bit value; equivalently floor((a*b + 16384) / 32768) truncated to 16 bits.
- R2: Lane i reads bits [16i+15:16i] of both operand vectors and writes the same bit range of the output.
- R3: A lane with both operands equal to 16'h8000 yields 16'h8000 (wrap, no saturation).
- R4: Mode 2'b00 computes lanes 0 to 7, and output bits [255:128] equal the prior destination input bits [255:128].
- R5: Mode 2'b01 computes lanes 0 to 7 and drives output bits [255:128] to zero.
- R6: Mode 2'b10 computes all sixteen lanes.
- R7: Mode 2'b11 behaves exactly like mode 2'b10.
- R8: No lane result depends on the operands of any other lane.
- R9: out_valid and out_data are updated one clock after a cycle with in_valid high. After a cycle with in_valid low, out_valid is low.
- R10: A synchronous active-high reset drives out_valid low on the following clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| mode | input | 2 | Width mode: 00 keep upper, 01 zero upper, 10/11 full width |
| src_a | input | 256 | First operand vector, sixteen signed 16-bit lanes |
| src_b | input | 256 | Second operand vector, sixteen signed 16-bit lanes |
| dst_prev | input | 256 | Prior destination value, upper half used in mode 00 |
| out_valid | output | 1 | Result valid |
| out_data | output | 256 | Packed lane results |

## Verification
Every result is due on the first rising edge after the cycle in which in_valid was sampled high, because one register lies on the path from input to output. The bench changes inputs on the falling edge. It reads outputs one time unit after the next rising edge, so each comparison covers exactly one transaction. The valid flag is checked against the same one-cycle lag, both when it rises and when it falls. The reset check reads out_valid one edge after reset is sampled.

// File: rtl/q15_mulhr_pkg.sv
package q15_mulhr_pkg;

    localparam int unsigned LANE_W   = 16;
    localparam int unsigned NUM_LANE = 16;

    // width mode encoding; the reserved code takes the full-width path
    typedef enum logic [1:0] {
        MODE_KEEP_HI = 2'b00,
        MODE_ZERO_HI = 2'b01,
        MODE_FULL    = 2'b10,
        MODE_RSVD    = 2'b11
    } width_mode_e;

endpackage

// File: rtl/q15_lane_mul.sv
module q15_lane_mul #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    localparam int unsigned PW = 2 * W;
    localparam int unsigned SH = W - 2;

    logic signed [PW-1:0] prod;
    logic        [W:0]    rnd;
    logic                 unused_bits;

    always_comb begin
        prod = $signed(a) * $signed(b);
        // window of the scaled product that survives truncation, then +1
        rnd  = prod[W+SH:SH] + {{W{1'b0}}, 1'b1};
        y    = rnd[W:1];
    end

    assign unused_bits = ^{prod[PW-1], prod[SH-1:0], rnd[0]};

endmodule

// File: rtl/q15_half_select.sv
module q15_half_select
    import q15_mulhr_pkg::*;
#(
    parameter int unsigned W     = 16,
    parameter int unsigned LANES = 16
) (
    input  logic [1:0]         mode,
    input  logic [W*LANES-1:0] lane_res,
    input  logic [W*LANES-1:0] dst_prev,
    output logic [W*LANES-1:0] merged
);
    localparam int unsigned HALF = LANES / 2;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        if (i < HALF) begin : g_low
            assign merged[W*i +: W] = lane_res[W*i +: W];
        end else begin : g_high
            always_comb begin
                unique case (width_mode_e'(mode))
                    MODE_KEEP_HI: merged[W*i +: W] = dst_prev[W*i +: W];
                    MODE_ZERO_HI: merged[W*i +: W] = '0;
                    default:      merged[W*i +: W] = lane_res[W*i +: W];
                endcase
            end
        end
    end

endmodule

// File: rtl/q15_mulhr_unit.sv
module q15_mulhr_unit
    import q15_mulhr_pkg::*;
#(
    parameter int unsigned W       = LANE_W,
    parameter int unsigned LANES   = NUM_LANE,
    parameter bit          PIPE_EN = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [1:0]           mode,
    input  logic [W*LANES-1:0]   src_a,
    input  logic [W*LANES-1:0]   src_b,
    input  logic [W*LANES-1:0]   dst_prev,
    output logic                 out_valid,
    output logic [W*LANES-1:0]   out_data
);
    localparam int unsigned VW = W * LANES;

    typedef struct packed {
        logic          vld;
        logic [VW-1:0] data;
    } stage_t;

    logic [VW-1:0] lane_res;
    logic [VW-1:0] merged;
    stage_t        stage_d;
    stage_t        stage_q;

    for (genvar i = 0; i < LANES; i++) begin : g_mul
        q15_lane_mul #(.W(W)) mul_i (
            .a (src_a[W*i +: W]),
            .b (src_b[W*i +: W]),
            .y (lane_res[W*i +: W])
        );
    end

    q15_half_select #(.W(W), .LANES(LANES)) sel_i (
        .mode     (mode),
        .lane_res (lane_res),
        .dst_prev (dst_prev),
        .merged   (merged)
    );

    always_comb begin
        stage_d      = stage_q;
        stage_d.vld  = in_valid;
        if (in_valid) begin
            stage_d.data = merged;
        end
    end

    if (PIPE_EN) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                stage_q <= '0;
            end else begin
                stage_q <= stage_d;
            end
        end
        assign out_valid = stage_q.vld;
        assign out_data  = stage_q.data;
    end else begin : g_comb
        assign stage_q   = '0;
        assign out_valid = stage_d.vld;
        assign out_data  = stage_d.data;
    end

endmodule

// File: rtl/q15_mulhr_chk.sv
module q15_mulhr_chk #(
    parameter int unsigned W       = 16,
    parameter int unsigned LANES   = 16,
    parameter bit          PIPE_EN = 1'b1
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic [1:0]           mode,
    input logic [W*LANES-1:0]   src_a,
    input logic [W*LANES-1:0]   src_b,
    input logic [W*LANES-1:0]   dst_prev,
    input logic                 out_valid,
    input logic [W*LANES-1:0]   out_data
);
    localparam int unsigned VW  = W * LANES;
    localparam int unsigned HW  = VW / 2;
    localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    if (PIPE_EN) begin : g_seq
        p_valid_follow_r9: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> out_valid);

        p_valid_drop_r9: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> !out_valid);

        p_reset_clear_r10: assert property (@(posedge clk)
            rst |=> !out_valid);

        p_keep_upper_r4: assert property (@(posedge clk) disable iff (rst)
            (in_valid && mode == 2'b00) |=> out_data[VW-1:HW] == $past(dst_prev[VW-1:HW]));

        p_zero_upper_r5: assert property (@(posedge clk) disable iff (rst)
            (in_valid && mode == 2'b01) |=> out_data[VW-1:HW] == '0);

        p_min_square_r3: assert property (@(posedge clk) disable iff (rst)
            (in_valid && src_a[W-1:0] == MINV && src_b[W-1:0] == MINV)
            |=> out_data[W-1:0] == MINV);

        p_zero_operand_r1: assert property (@(posedge clk) disable iff (rst)
            (in_valid && src_a[W-1:0] == '0) |=> out_data[W-1:0] == '0);
    end

endmodule

bind q15_mulhr_unit q15_mulhr_chk #(
    .W       (W),
    .LANES   (LANES),
    .PIPE_EN (PIPE_EN)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .mode      (mode),
    .src_a     (src_a),
    .src_b     (src_b),
    .dst_prev  (dst_prev),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/q15_mulhr_unit_tb_top.sv
module q15_mulhr_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [1:0]   mode;
    logic [255:0] src_a, src_b, dst_prev;
    logic         out_valid;
    logic [255:0] out_data;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    q15_mulhr_unit dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .mode      (mode),
        .src_a     (src_a),
        .src_b     (src_b),
        .dst_prev  (dst_prev),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    // arithmetic model: nearest value of p / 2^15, ties upward
    function automatic logic [15:0] ref_lane(input logic [15:0] a, input logic [15:0] b);
        int p;
        int t;
        p = int'($signed(a)) * int'($signed(b));
        t = (p + 16384) >>> 15;
        return t[15:0];
    endfunction

    function automatic logic [255:0] ref_vec(input logic [1:0] m, input logic [255:0] a,
                                             input logic [255:0] b, input logic [255:0] d);
        logic [255:0] r;
        for (int i = 0; i < 16; i++) begin
            if (i < 8 || m[1])      r[16*i +: 16] = ref_lane(a[16*i +: 16], b[16*i +: 16]);
            else if (m == 2'b00)    r[16*i +: 16] = d[16*i +: 16];
            else                    r[16*i +: 16] = 16'h0000;
        end
        return r;
    endfunction

    task automatic check_bit(input string tag, input logic got, input logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic check_vec(input string tag_lo, input logic [1:0] m, input logic [255:0] exp);
        string tag_hi;
        case (m)
            2'b00:   tag_hi = "R4";
            2'b01:   tag_hi = "R5";
            2'b10:   tag_hi = "R6";
            default: tag_hi = "R7";
        endcase
        for (int i = 0; i < 16; i++) begin
            total++;
            if (out_data[16*i +: 16] !== exp[16*i +: 16]) begin
                bad++;
                $display("FAIL %s lane %0d: got %h expected %h",
                         (i < 8) ? tag_lo : tag_hi, i, out_data[16*i +: 16], exp[16*i +: 16]);
            end
        end
    endtask

    task automatic send(input string tag_lo, input logic [1:0] m, input logic [255:0] a,
                        input logic [255:0] b, input logic [255:0] d);
        @(negedge clk);
        in_valid = 1'b1;
        mode     = m;
        src_a    = a;
        src_b    = b;
        dst_prev = d;
        @(posedge clk);
        #1;
        check_bit("R9 valid rise", out_valid, 1'b1);
        check_vec(tag_lo, m, ref_vec(m, a, b, d));
    endtask

    function automatic logic [255:0] rnd_vec();
        logic [255:0] v;
        for (int k = 0; k < 8; k++) v[32*k +: 32] = $urandom;
        return v;
    endfunction

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] vals [12];
        logic [255:0] a, b, d;
        vals = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h8001,
                 16'h4000, 16'hC000, 16'h2000, 16'h7FFE, 16'h00FF, 16'hA5A5};
        void'($urandom(32'h5EED));

        rst = 1'b1; in_valid = 1'b0; mode = 2'b00;
        src_a = '0; src_b = '0; dst_prev = '0;
        repeat (3) @(posedge clk);
        #1;
        check_bit("R10 reset", out_valid, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        // R1, R4..R7: every pair of edge values, all four modes
        for (int m = 0; m < 4; m++) begin
            for (int v = 0; v < 9; v++) begin
                for (int l = 0; l < 16; l++) begin
                    a[16*l +: 16] = vals[(16*v + l) / 12];
                    b[16*l +: 16] = vals[(16*v + l) % 12];
                end
                d = rnd_vec();
                send("R1", m[1:0], a, b, d);
            end
        end

        // R3: extreme square in every lane, full width
        send("R3", 2'b10, {16{16'h8000}}, {16{16'h8000}}, '0);
        check_bit("R3 lane0 value", out_data[15:0] == 16'h8000, 1'b1);

        // R2: one active lane at a time
        for (int l = 0; l < 16; l++) begin
            a = '0; b = '0;
            a[16*l +: 16] = 16'h7FFF;
            b[16*l +: 16] = 16'h4000;
            send("R2", 2'b10, a, b, {16{16'hFFFF}});
        end

        // R8: alternating extremes in neighbouring lanes
        for (int l = 0; l < 16; l++) begin
            a[16*l +: 16] = l[0] ? 16'h8000 : 16'h7FFF;
            b[16*l +: 16] = l[0] ? 16'h8000 : 16'h8001;
        end
        send("R8", 2'b11, a, b, '0);
        send("R8", 2'b10, ~a, b, '0);

        // random vectors across modes
        for (int n = 0; n < 200; n++) begin
            send("R1", 2'(n % 4), rnd_vec(), rnd_vec(), rnd_vec());
        end

        // R9: valid falls one clock after in_valid drops
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk);
        #1;
        check_bit("R9 valid drop", out_valid, 1'b0);

        // R10: reset in the middle of traffic
        send("R1", 2'b10, rnd_vec(), rnd_vec(), '0);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check_bit("R10 mid reset", out_valid, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        in_valid = 1'b0;

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule